// File: doc/BRIEF.md
# PHY Configuration Register Handshake Bridge

This block connects one 32-bit host control word to a small file of 8-bit PHY configuration entries with 6-bit addresses. The host never writes an entry directly. It loads the target address and data into the control word, raises a write or read request bit, waits for the acknowledge bit in the same word to go high, drops the request and waits for the acknowledge to go low again. This four-phase level handshake makes every access self-timed. Start-up software can then program a list of delay settings one entry after another and stop at the first access that does not complete.

The entry file holds the per-speed input delay settings and the clock, high-speed and strobe delay-line settings, at addresses 0 to `NENT-1`. Higher addresses are acknowledged but have no storage. A sticky timeout bit reports an acknowledge that stays high for too long while the request is held.

Top module: `phy_cfg_bridge`

## Requirements
- R1: After reset the host readback word is all zeros and every entry holds zero.
- R2: A host write loads address bits 5:0, write data bits 15:8, write request bit 24 and read request bit 25. These fields read back unchanged. Bits 30:27 and 7:6 always read zero.
- R3: The acknowledge, bit 26, rises exactly `ACK_LAT` cycles after the request (bit 24 or bit 25) rises.
- R4: The acknowledge stays high while the request is held. It falls on the cycle after the request drops.
- R5: A write request stores the write data into the entry at the address when the acknowledge rises.
- R6: A read request places the addressed entry in bits 23:16 when the acknowledge rises. The value holds there until the next read-only access is acknowledged.
- R7: Addresses at or above `NENT` read as zero and writes to them are dropped, but they are acknowledged with the same timing.
- R8: Changing the address or data while the acknowledge is high, with the request still set, starts no new access and changes no entry.
- R9: Timeout bit 31 is set and stays set when the acknowledge has been high with the request held for `TO_CYC` cycles. Any host write clears it. It stays clear during accesses that complete normally.
- R10: When both request bits are set, the write is performed and bits 23:16 are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Control word written by the host |
| host_rdata | output | 32 | Control word readback, including acknowledge, read data and timeout |

## Verification
The hardest state to reach is an acknowledge that is still high when the host rewrites the control word with the request still set. An ordinary handshake never leaves the request set after the acknowledge arrives. Directed cases hold the request past the acknowledge to test the ignored rewrite. They also hold it for more than `TO_CYC` cycles to set the timeout bit. Seeded random accesses run in between, with random addresses both inside and outside the entry range and random request kinds, including both request bits set at once.

// File: rtl/phy_cfg_bridge.sv
module phy_cfg_bridge #(
  parameter int AW      = 6,
  parameter int DW      = 8,
  parameter int NENT    = 14,
  parameter int ACK_LAT = 4,
  parameter int TO_CYC  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int CW     = $clog2(TO_CYC + ACK_LAT + 2);
  localparam int WD_LO  = 8;
  localparam int RD_LO  = 16;
  localparam int WR_BIT = 24;
  localparam int RQ_BIT = 25;

  typedef enum logic [1:0] {IDLE, WAIT, ACKD} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q, rd_val;
  logic           wr_q, rd_q, to_q;
  logic [DW-1:0]  ent [NENT];

  wire req    = wr_q | rd_q;
  wire ack    = (st == ACKD);
  wire commit = (st == WAIT) && req && (cnt == CW'(ACK_LAT - 1));

  assign host_rdata = {to_q, 4'b0, ack, rd_q, wr_q, rdata_q, wdata_q, 2'b0, addr_q};

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NENT; i++)
      if (addr_q == AW'(i)) rd_val = ent[i];
  end

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk)
      if (!rst_n) ent[g] <= '0;
      else if (commit && wr_q && addr_q == AW'(g)) ent[g] <= wdata_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else if (host_wr) begin
      addr_q  <= host_wdata[AW-1:0];
      wdata_q <= host_wdata[WD_LO +: DW];
      wr_q    <= host_wdata[WR_BIT];
      rd_q    <= host_wdata[RQ_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      rdata_q <= '0;
      to_q    <= 1'b0;
    end else begin
      if (host_wr) to_q <= 1'b0;
      else if (ack && req && cnt == CW'(TO_CYC - 1)) to_q <= 1'b1;
      case (st)
        IDLE: if (req) begin
          st  <= WAIT;
          cnt <= CW'(1);
        end
        WAIT: if (!req) st <= IDLE;
          else if (commit) begin
            st  <= ACKD;
            cnt <= '0;
            if (rd_q && !wr_q) rdata_q <= rd_val;
          end else cnt <= cnt + 1'b1;
        ACKD: if (!req) st <= IDLE;
          else if (cnt < CW'(TO_CYC)) cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  // R3
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> req);
  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req) |=> ack);
  // R4
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> !$past(req));
  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ack) |-> $stable(rdata_q));
  // R9
  to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> !to_q);
  // R9
  to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> $past(ack));
endmodule

// File: tb/sim_phy_cfg_bridge.sv
module sim_phy_cfg_bridge;
  localparam int CLK_P   = 10;
  localparam int NENT    = 14;
  localparam int ACK_LAT = 4;
  localparam int TO_CYC  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  int          checks = 0, errors = 0;
  logic [7:0]  model [64];
  logic [7:0]  last_rd = '0;

  phy_cfg_bridge #(.AW(6), .DW(8), .NENT(NENT), .ACK_LAT(ACK_LAT), .TO_CYC(TO_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] exp_ent(input logic [5:0] a);
    return (a < NENT) ? model[a] : 8'h00;
  endfunction

  function automatic logic [31:0] mk(input logic wr, input logic rd, input logic [5:0] a, input logic [7:0] d);
    return {6'b0, rd, wr, 8'h00, d, 2'b00, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic host_write(input logic [31:0] w);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic raise_and_wait(input logic wr, input logic rd, input logic [5:0] a, input logic [7:0] d);
    host_write(mk(wr, rd, a, d));
    repeat (ACK_LAT - 1) @(negedge clk);
    chk("R3 ack still low", {31'b0, host_rdata[26]}, 32'd0);
    @(negedge clk);
    chk("R3 ack high after latency", {31'b0, host_rdata[26]}, 32'd1);
    chk("R9 no timeout in normal access", {31'b0, host_rdata[31]}, 32'd0);
  endtask

  task automatic drop_req(input logic [5:0] a, input logic [7:0] d);
    host_write(mk(1'b0, 1'b0, a, d));
    chk("R4 ack held in drop cycle", {31'b0, host_rdata[26]}, 32'd1);
    @(negedge clk);
    chk("R4 ack falls", {31'b0, host_rdata[26]}, 32'd0);
  endtask

  task automatic access(input logic wr, input logic rd, input logic [5:0] a, input logic [7:0] d);
    host_write(mk(1'b0, 1'b0, a, d));
    chk("R2 fields load", host_rdata & 32'hFBFF_FF3F, {8'h00, last_rd, d, 2'b00, a});
    raise_and_wait(wr, rd, a, d);
    if (wr && a < NENT) model[a] = d;
    if (rd && !wr) last_rd = exp_ent(a);
    chk(rd && !wr ? "R6 read data" : (wr && rd ? "R10 rdata kept" : "R6 rdata held over write"),
        {24'b0, host_rdata[23:16]}, {24'b0, last_rd});
    drop_req(a, d);
  endtask

  task automatic read_chk(input string req, input logic [5:0] a);
    access(1'b0, 1'b1, a, 8'h00);
    chk(req, {24'b0, host_rdata[23:16]}, {24'b0, exp_ent(a)});
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset readback", host_rdata, 32'h0);
    read_chk("R1 entry zero after reset", 6'd7);

    // R5 startup-style sequence over all implemented entries
    for (int a = 0; a < NENT; a++) access(1'b1, 1'b0, 6'(a), 8'(8'h30 + a * 7));
    for (int a = 0; a < NENT; a++) read_chk("R5 entry stored", 6'(a));

    // R2 unused bits stay zero
    host_write(32'hFFFF_FFFF & ~32'h0300_0000);
    chk("R2 unused bits zero", host_rdata & 32'h7800_00C0, 32'h0);
    host_write(32'h0);

    // R7 out-of-range
    access(1'b1, 1'b0, 6'd40, 8'hFF);
    read_chk("R7 out of range reads zero", 6'd40);
    read_chk("R7 max address reads zero", 6'd63);
    read_chk("R7 neighbour untouched", 6'd13);

    // R8 rewrite while ack high
    raise_and_wait(1'b1, 1'b0, 6'd3, 8'h22);
    model[3] = 8'h22;
    host_write(mk(1'b1, 1'b0, 6'd5, 8'h77));
    repeat (ACK_LAT + 2) @(negedge clk);
    chk("R8 ack stays high", {31'b0, host_rdata[26]}, 32'd1);
    drop_req(6'd5, 8'h77);
    read_chk("R8 second address untouched", 6'd5);
    read_chk("R8 first write landed", 6'd3);

    // R9 timeout
    raise_and_wait(1'b1, 1'b0, 6'd2, 8'hA5);
    model[2] = 8'hA5;
    repeat (TO_CYC - 3) @(negedge clk);
    chk("R9 not yet timed out", {31'b0, host_rdata[31]}, 32'd0);
    repeat (6) @(negedge clk);
    chk("R9 timeout set", {31'b0, host_rdata[31]}, 32'd1);
    repeat (10) @(negedge clk);
    chk("R9 timeout sticky", {31'b0, host_rdata[31]}, 32'd1);
    drop_req(6'd2, 8'hA5);
    chk("R9 cleared by host write", {31'b0, host_rdata[31]}, 32'd0);
    read_chk("R9 entry written", 6'd2);

    // R10 both requests
    access(1'b1, 1'b1, 6'd4, 8'h5A);
    read_chk("R10 write performed", 6'd4);

    // random mix
    for (int n = 0; n < 120; n++) begin
      logic [1:0] k;
      logic [5:0] a;
      k = 2'($urandom_range(0, 3));
      a = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63)) : 6'($urandom_range(0, NENT - 1));
      case (k)
        2'd0: access(1'b1, 1'b0, a, 8'($urandom));
        2'd1: read_chk("R6 random read", a);
        2'd2: access(1'b1, 1'b1, a, 8'($urandom));
        default: read_chk("R5 random readback", a);
      endcase
    end
    finish_sim();
  end
endmodule